// File: doc/BRIEF.md
# Packed FP32 to Unsigned 64-bit Converter

This block takes a 256-bit vector holding up to eight IEEE-754 single-precision values and turns each active element into an unsigned 64-bit integer. The results go into a 512-bit destination. The caller chooses two, four or eight lanes. It also chooses one of four rounding modes, either from a global field or from a per-operation embedded field. Per-lane write masking can either merge with the previous destination or zero the lane. A broadcast option makes every lane read element 0 of a memory-style source. A value that does not fit saturates to all ones and raises the invalid flag. An inexact conversion raises the precision flag.

One operation is accepted on each cycle that `in_valid` is high. The result and its two flags appear one cycle later with `out_valid`. A two-state output machine governs `out_valid`:

- In `ST_IDLE`, no result is presented. `ST_IDLE` goes to `ST_OUT` when `in_valid` is high.
- In `ST_OUT`, a fresh result is presented. `ST_OUT` stays in `ST_OUT` when `in_valid` is high again, and returns to `ST_IDLE` otherwise.

The data registers keep the last result while the machine is idle.

Top module: `pk_f2u64_cvt`

## Requirements
- R1: While `rst_n` is low, and until the first accepted operation, `out_valid`, `dst`, `flag_inv` and `flag_pe` are all zero.
- R2: An operation presented with `in_valid` high gives `out_valid` high exactly one cycle later, with its result and flags. `out_valid` is low in a cycle that follows a cycle with `in_valid` low, and `dst` then keeps its last value.
- R3: `vlen_sel` selects the number of active lanes: 00 gives 2 lanes, 01 gives 4 lanes, 10 or 11 gives 8 lanes. Source lane j is `src[32j+31:32j]` and destination lane j is `dst[64j+63:64j]`. Every destination bit above the active lanes is zero.
- R4: An active, enabled lane holds its input rounded to an integer under the selected mode. The mode encoding is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R5: `er_rc` replaces `glb_rc` only when `er_en` is 1, `mem_src` is 0 and `vlen_sel` selects 8 lanes. In every other case `glb_rc` is used.
- R6: A NaN, an infinity, a value whose rounded magnitude is at least 2^64, or a negative value that rounds to a nonzero integer produces all ones in its lane and sets `flag_inv`. Such a lane does not set `flag_pe`.
- R7: A negative value that rounds to zero gives 0 and sets `flag_pe` if it was nonzero. A subnormal input gives 0 or 1 according to the rounding mode and sets `flag_pe`.
- R8: `flag_pe` is set when any enabled lane's conversion is inexact and valid. Exact conversions leave it clear.
- R9: With `mask_en` = 1, an active lane whose `mask` bit is 0 takes `old_dst`'s lane when `zero_mode` = 0 and takes zero when `zero_mode` = 1.
- R10: With `mask_en` = 0, every active lane is converted whatever the `mask` bits are.
- R11: With `bcast` = 1 and `mem_src` = 1, every active lane converts `src[31:0]`. With `mem_src` = 0, `bcast` has no effect.
- R12: The flags are the OR over the active lanes that are enabled by the mask. Lanes that are masked off or above the active lanes never set a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 256 | Packed single-precision source, lane j at bits 32j+31:32j |
| vlen_sel | input | 2 | Lane count: 00 = 2, 01 = 4, 10/11 = 8 |
| mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Apply `mask` when 1 |
| zero_mode | input | 1 | Masked-off lanes: 1 = zero, 0 = merge with `old_dst` |
| bcast | input | 1 | Broadcast element 0 (memory-style source only) |
| mem_src | input | 1 | Source is memory-style |
| er_en | input | 1 | Embedded rounding request |
| er_rc | input | 2 | Embedded rounding mode |
| glb_rc | input | 2 | Global rounding mode |
| old_dst | input | 512 | Previous destination value, used for merging |
| out_valid | output | 1 | Result presented |
| dst | output | 512 | Converted destination |
| flag_inv | output | 1 | Invalid flag of the presented result |
| flag_pe | output | 1 | Precision (inexact) flag of the presented result |

## Verification
The assertions check the handshake of the output machine on every cycle. They also check that all bits above two or four lanes stay zero, that an invalid lane always reads all ones, that masked-off or inactive lanes stay silent in the flags, and that lane 0 is kept unchanged under merge masking. Only the bench scenarios can show that the numbers are right. That covers rounding in each mode near ties and at the 2^64 limit, negative and subnormal handling, the choice of rounding source, and broadcast.

// File: rtl/pkcvt_pkg.sv
package pkcvt_pkg;

    localparam int LANES_MAX = 8;
    localparam int SRC_W     = 32;
    localparam int DST_W     = 64;
    localparam int SRC_VEC_W = LANES_MAX * SRC_W;
    localparam int DST_VEC_W = LANES_MAX * DST_W;

    typedef enum logic [1:0] {
        RC_NEAR  = 2'b00,
        RC_DOWN  = 2'b01,
        RC_UP    = 2'b10,
        RC_TRUNC = 2'b11
    } rmode_e;

    typedef struct packed {
        logic [DST_W-1:0] val;
        logic             inv;
        logic             pe;
    } lane_out_t;

    // 00 -> 2 lanes, 01 -> 4 lanes, 10/11 -> 8 lanes
    function automatic int lanes_of(input logic [1:0] sel);
        int n;
        unique case (sel)
            2'b00:   n = 2;
            2'b01:   n = 4;
            default: n = LANES_MAX;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/f2u64_core.sv
module f2u64_core
    import pkcvt_pkg::*;
(
    input  logic [SRC_W-1:0] fin,
    input  rmode_e           rm,
    output lane_out_t        res
);
    localparam int MW    = 24;          // significand incl. hidden bit
    localparam int FRACW = MW + 1;      // guard field for shifting
    localparam int BIAS  = 127;

    logic             sgn;
    logic [7:0]       ex, ex_eff;
    logic [MW-1:0]    mant;
    logic [MW+FRACW-1:0] ext;
    logic [MW-1:0]    ipart;
    logic             rb, sb, inc;
    logic [DST_W-1:0] mag;
    int               e_unb, sh;

    always_comb begin
        sgn    = fin[31];
        ex     = fin[30:23];
        ex_eff = (ex == 8'd0) ? 8'd1 : ex;
        mant   = {ex != 8'd0, fin[22:0]};
        e_unb  = int'(ex_eff) - BIAS;
        sh     = 0;
        ext    = '0;
        ipart  = '0;
        rb     = 1'b0;
        sb     = 1'b0;
        inc    = 1'b0;
        mag    = '0;
        res    = '{val: '0, inv: 1'b0, pe: 1'b0};

        if (ex == 8'hFF || e_unb >= DST_W) begin
            res = '{val: '1, inv: 1'b1, pe: 1'b0};
        end else begin
            if (e_unb >= MW - 1) begin
                mag = {{(DST_W-MW){1'b0}}, mant} << (e_unb - (MW - 1));
            end else begin
                sh = (MW - 1) - e_unb;
                if (sh >= FRACW) begin
                    ipart = '0;
                    rb    = 1'b0;
                    sb    = |mant;
                end else begin
                    ext   = {mant, {FRACW{1'b0}}} >> sh;
                    ipart = ext[MW+FRACW-1:FRACW];
                    rb    = ext[FRACW-1];
                    sb    = |ext[FRACW-2:0];
                end
                unique case (rm)
                    RC_NEAR:  inc = rb & (sb | ipart[0]);
                    RC_DOWN:  inc = sgn & (rb | sb);
                    RC_UP:    inc = ~sgn & (rb | sb);
                    RC_TRUNC: inc = 1'b0;
                    default:  inc = 1'b0;
                endcase
                mag = {{(DST_W-MW){1'b0}}, ipart} + {{(DST_W-1){1'b0}}, inc};
            end

            if (!sgn || mag == '0) begin
                res = '{val: sgn ? '0 : mag, inv: 1'b0, pe: rb | sb};
            end else begin
                res = '{val: '1, inv: 1'b1, pe: 1'b0};
            end
        end
    end

endmodule

// File: rtl/f2u64_slot.sv
module f2u64_slot
    import pkcvt_pkg::*;
(
    input  logic [SRC_W-1:0] elem,
    input  rmode_e           rm,
    input  logic             active,
    input  logic             enabled,
    input  logic             zero_mode,
    input  logic [DST_W-1:0] old_lane,
    output logic [DST_W-1:0] lane_val,
    output logic             lane_inv,
    output logic             lane_pe
);
    lane_out_t conv;

    f2u64_core u_core (
        .fin (elem),
        .rm  (rm),
        .res (conv)
    );

    always_comb begin
        if (enabled) begin
            lane_val = conv.val;
        end else if (active && !zero_mode) begin
            lane_val = old_lane;
        end else begin
            lane_val = '0;
        end
        lane_inv = enabled & conv.inv;
        lane_pe  = enabled & conv.pe;
    end

endmodule

// File: rtl/pk_f2u64_cvt.sv
module pk_f2u64_cvt
    import pkcvt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SRC_VEC_W-1:0] src,
    input  logic [1:0]           vlen_sel,
    input  logic [LANES_MAX-1:0] mask,
    input  logic                 mask_en,
    input  logic                 zero_mode,
    input  logic                 bcast,
    input  logic                 mem_src,
    input  logic                 er_en,
    input  logic [1:0]           er_rc,
    input  logic [1:0]           glb_rc,
    input  logic [DST_VEC_W-1:0] old_dst,
    output logic                 out_valid,
    output logic [DST_VEC_W-1:0] dst,
    output logic                 flag_inv,
    output logic                 flag_pe
);
    typedef enum logic {ST_IDLE = 1'b0, ST_OUT = 1'b1} ostate_e;

    ostate_e state_q, state_d;

    int             n_act;
    logic           er_eff, bc_eff;
    rmode_e         rm_sel;
    logic [LANES_MAX-1:0] lane_act, lane_en, lane_inv, lane_pe;
    logic [DST_W-1:0]     lane_val [LANES_MAX];
    logic [DST_VEC_W-1:0] nxt_dst;

    always_comb begin
        n_act  = lanes_of(vlen_sel);
        er_eff = er_en & ~mem_src & (n_act == LANES_MAX);
        bc_eff = bcast & mem_src;
        rm_sel = rmode_e'(er_eff ? er_rc : glb_rc);
    end

    generate
        for (genvar j = 0; j < LANES_MAX; j++) begin : g_lane
            logic [SRC_W-1:0] elem;
            assign lane_act[j] = (j < n_act);
            assign lane_en[j]  = lane_act[j] & (~mask_en | mask[j]);
            assign elem        = bc_eff ? src[SRC_W-1:0] : src[j*SRC_W +: SRC_W];

            f2u64_slot u_slot (
                .elem      (elem),
                .rm        (rm_sel),
                .active    (lane_act[j]),
                .enabled   (lane_en[j]),
                .zero_mode (zero_mode),
                .old_lane  (old_dst[j*DST_W +: DST_W]),
                .lane_val  (lane_val[j]),
                .lane_inv  (lane_inv[j]),
                .lane_pe   (lane_pe[j])
            );

            assign nxt_dst[j*DST_W +: DST_W] = lane_val[j];

            // R6: an invalid lane carries the saturated all-ones value
            a_r6_inv_ones: assert property (@(posedge clk) disable iff (!rst_n)
                lane_inv[j] |-> (lane_val[j] == '1));
            // R12: lanes not enabled stay silent in both flags
            a_r12_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
                !lane_en[j] |-> (!lane_inv[j] && !lane_pe[j]));
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_OUT;
            ST_OUT:  if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst      <= '0;
            flag_inv <= 1'b0;
            flag_pe  <= 1'b0;
        end else if (in_valid) begin
            dst      <= nxt_dst;
            flag_inv <= |lane_inv;
            flag_pe  <= |lane_pe;
        end
    end

    assign out_valid = (state_q == ST_OUT);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_upper_zero_two: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(vlen_sel) == 2'b00) |-> (dst[DST_VEC_W-1:2*DST_W] == '0));
    a_r3_upper_zero_four: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(vlen_sel) == 2'b01) |-> (dst[DST_VEC_W-1:4*DST_W] == '0));
    a_r9_merge_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mask_en && !mask[0] && !zero_mode))
            |-> (dst[DST_W-1:0] == $past(old_dst[DST_W-1:0])));

endmodule

// File: tb/pk_f2u64_cvt_bench.sv
`timescale 1ns/1ps
module pk_f2u64_cvt_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] src = '0;
    logic [1:0]   vlen_sel = 2'b00;
    logic [7:0]   mask = '0;
    logic         mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0, mem_src = 1'b0, er_en = 1'b0;
    logic [1:0]   er_rc = 2'b00, glb_rc = 2'b00;
    logic [511:0] old_dst = '0;
    logic         out_valid, flag_inv, flag_pe;
    logic [511:0] dst;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pk_f2u64_cvt u_pk_f2u64_cvt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .vlen_sel(vlen_sel),
        .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
        .mem_src(mem_src), .er_en(er_en), .er_rc(er_rc), .glb_rc(glb_rc),
        .old_dst(old_dst), .out_valid(out_valid), .dst(dst),
        .flag_inv(flag_inv), .flag_pe(flag_pe)
    );

    typedef struct packed {
        logic [31:0] f;
        logic [1:0]  rc;
        logic [63:0] q;
        logic        inv;
        logic        pe;
    } vec_t;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NV = 29;
    localparam vec_t TBL [NV] = '{
        '{32'h3F800000, 2'd0, 64'd1, 1'b0, 1'b0},
        '{32'h3FC00000, 2'd0, 64'd2, 1'b0, 1'b1},
        '{32'h3FC00000, 2'd1, 64'd1, 1'b0, 1'b1},
        '{32'h3FC00000, 2'd2, 64'd2, 1'b0, 1'b1},
        '{32'h3FC00000, 2'd3, 64'd1, 1'b0, 1'b1},
        '{32'h40200000, 2'd0, 64'd2, 1'b0, 1'b1},
        '{32'h40600000, 2'd0, 64'd4, 1'b0, 1'b1},
        '{32'h3F000000, 2'd0, 64'd0, 1'b0, 1'b1},
        '{32'h3F000000, 2'd2, 64'd1, 1'b0, 1'b1},
        '{32'hBF000000, 2'd0, 64'd0, 1'b0, 1'b1},
        '{32'hBF000000, 2'd1, ONES,  1'b1, 1'b0},
        '{32'hBF000000, 2'd2, 64'd0, 1'b0, 1'b1},
        '{32'hBF800000, 2'd3, ONES,  1'b1, 1'b0},
        '{32'h80000000, 2'd1, 64'd0, 1'b0, 1'b0},
        '{32'h7FC00000, 2'd0, ONES,  1'b1, 1'b0},
        '{32'h7F800000, 2'd3, ONES,  1'b1, 1'b0},
        '{32'hFF800000, 2'd0, ONES,  1'b1, 1'b0},
        '{32'h5F000000, 2'd0, 64'h8000_0000_0000_0000, 1'b0, 1'b0},
        '{32'h5F800000, 2'd3, ONES,  1'b1, 1'b0},
        '{32'h5F7FFFFF, 2'd0, 64'hFFFF_FF00_0000_0000, 1'b0, 1'b0},
        '{32'h4B7FFFFF, 2'd0, 64'h0000_0000_00FF_FFFF, 1'b0, 1'b0},
        '{32'h3F7FFFFF, 2'd0, 64'd1, 1'b0, 1'b1},
        '{32'h3F7FFFFF, 2'd3, 64'd0, 1'b0, 1'b1},
        '{32'h00000001, 2'd2, 64'd1, 1'b0, 1'b1},
        '{32'h00000001, 2'd0, 64'd0, 1'b0, 1'b1},
        '{32'h80000001, 2'd1, ONES,  1'b1, 1'b0},
        '{32'h80000001, 2'd2, 64'd0, 1'b0, 1'b1},
        '{32'h3E800000, 2'd0, 64'd0, 1'b0, 1'b1},
        '{32'h3E800000, 2'd2, 64'd1, 1'b0, 1'b1}
    };

    // floats 1.0 .. 8.0 in lanes 0..7
    localparam logic [255:0] SEQ8 = {32'h41000000, 32'h40E00000, 32'h40C00000, 32'h40A00000,
                                     32'h40800000, 32'h40400000, 32'h40000000, 32'h3F800000};

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic go();
        @(negedge clk) in_valid = 1'b1;
        @(negedge clk) in_valid = 1'b0;
    endtask

    task automatic defaults();
        vlen_sel = 2'b00; mask = '0; mask_en = 1'b0; zero_mode = 1'b0; bcast = 1'b0;
        mem_src = 1'b0; er_en = 1'b0; er_rc = 2'b00; glb_rc = 2'b00; old_dst = '0; src = '0;
    endtask

    function automatic logic [511:0] seq_lanes(input int n);
        logic [511:0] r = '0;
        for (int j = 0; j < n; j++) r[j*64 +: 64] = 64'(j + 1);
        return r;
    endfunction

    initial begin
        logic [511:0] exp;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", {511'b0, out_valid}, '0);
        chk("R1 dst", dst, '0);
        chk("R1 flags", {510'b0, flag_inv, flag_pe}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {509'b0, out_valid, flag_inv, flag_pe}, '0);

        // table walk: R4 R6 R7 R8 on lane 0, two lanes
        for (int i = 0; i < NV; i++) begin
            defaults();
            src[31:0] = TBL[i].f;
            glb_rc    = TBL[i].rc;
            go();
            chk($sformatf("R4/R6/R7 table %0d value", i), dst, {448'b0, TBL[i].q});
            chk($sformatf("R6/R8 table %0d flags", i), {510'b0, flag_inv, flag_pe},
                {510'b0, TBL[i].inv, TBL[i].pe});
        end

        // R2: valid timing and hold
        defaults(); src = SEQ8; vlen_sel = 2'b10;
        go();
        chk("R2 valid one cycle later", {511'b0, out_valid}, 512'd1);
        chk("R3 eight lanes", dst, seq_lanes(8));
        @(negedge clk);
        chk("R2 valid drops", {511'b0, out_valid}, '0);
        chk("R2 dst holds", dst, seq_lanes(8));

        // R3: four lanes, upper zero even with old_dst all ones
        defaults(); src = SEQ8; vlen_sel = 2'b01; old_dst = '1;
        go();
        chk("R3 four lanes", dst, seq_lanes(4));
        defaults(); src = SEQ8; vlen_sel = 2'b11;
        go();
        chk("R3 sel 11 eight lanes", dst, seq_lanes(8));

        // R9: merge masking
        defaults(); src = SEQ8; vlen_sel = 2'b10; mask_en = 1'b1; mask = 8'hA5;
        for (int j = 0; j < 8; j++) old_dst[j*64 +: 64] = 64'h0123_4567_0000_0000 | 64'(j);
        go();
        exp = '0;
        for (int j = 0; j < 8; j++)
            exp[j*64 +: 64] = mask[j] ? 64'(j + 1) : (64'h0123_4567_0000_0000 | 64'(j));
        chk("R9 merge", dst, exp);
        zero_mode = 1'b1;
        go();
        for (int j = 0; j < 8; j++) exp[j*64 +: 64] = mask[j] ? 64'(j + 1) : 64'd0;
        chk("R9 zero", dst, exp);

        // R10: mask ignored when disabled
        mask_en = 1'b0; mask = 8'h00;
        go();
        chk("R10 mask ignored", dst, seq_lanes(8));

        // R12: masked-off and inactive lanes do not raise flags
        defaults(); vlen_sel = 2'b01; mask_en = 1'b1; mask = 8'hFD;
        src[63:32] = 32'h7FC00000;   // lane 1 masked off
        src[31:0]  = 32'h3F800000;
        go();
        chk("R12 masked lane quiet", {510'b0, flag_inv, flag_pe}, '0);
        defaults(); vlen_sel = 2'b00;
        src[127:96] = 32'h7FC00000;  // lane 3 above two lanes
        src[223:192] = 32'h3FC00000; // lane 6 inexact, inactive
        go();
        chk("R12 inactive lanes quiet", {510'b0, flag_inv, flag_pe}, '0);
        chk("R3 inactive lanes zero", dst, '0);

        // R11: broadcast
        defaults(); src = SEQ8; src[31:0] = 32'h40400000; vlen_sel = 2'b10; bcast = 1'b1; mem_src = 1'b1;
        go();
        exp = '0;
        for (int j = 0; j < 8; j++) exp[j*64 +: 64] = 64'd3;
        chk("R11 broadcast", dst, exp);
        mem_src = 1'b0;
        go();
        exp = seq_lanes(8); exp[63:0] = 64'd3;
        chk("R11 register source ignores bcast", dst, exp);

        // R5: rounding source
        defaults(); src[31:0] = 32'h3FC00000; vlen_sel = 2'b10; er_en = 1'b1;
        er_rc = 2'b10; glb_rc = 2'b11;
        go();
        chk("R5 embedded used", dst[63:0], 512'd2);
        vlen_sel = 2'b01;
        go();
        chk("R5 short vector uses global", dst[63:0], 512'd1);
        vlen_sel = 2'b10; mem_src = 1'b1;
        go();
        chk("R5 memory source uses global", dst[63:0], 512'd1);

        // R8: mixed lanes, flags OR
        defaults(); vlen_sel = 2'b01; src[31:0] = 32'h3F800000; src[95:64] = 32'h3FC00000;
        go();
        chk("R8 any inexact", {510'b0, flag_inv, flag_pe}, 512'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule